// File: doc/BRIEF.md
# ARINC 429 Self-Test Serializer

This block holds one 32-bit test word and sends it as return-to-zero ARINC 429 serial data. The host presents a word together with one of two load strobes. One strobe picks the fast rate and the other picks the slow rate, so each word carries its own speed. Transmission begins on the cycle after the load is accepted. Bits leave in the order they were loaded: bit 0 of the word goes first, then bit 1, and so on up to bit 31. After the last bit the line rests for a fixed gap, and then the block reports that it is free again.

The line state appears on two wires, one for a ONE and one for a ZERO; both low means NULL. The same stream also feeds a bank of receiver channels. Each channel has its own select bit, which chooses between this internal loopback stream and that channel's external bus. Bit timing comes from a divider of the system clock. The defaults give 100 kbit/s and 12.5 kbit/s from a 1 MHz clock.

Top module: `arinc_selftest_tx`

## Requirements
- R1: While reset is held and right after it, `busy` is 0 and the line is NULL (`tx_one`=0, `tx_zero`=0).
- R2: A load accepted with `load_hi` uses a bit period of 2*HALF_HI_CYC clocks. The first bit starts on the first cycle after the accepting clock edge.
- R3: A load accepted with only `load_lo` uses a bit period of 2*HALF_HI_CYC*LO_RATIO clocks.
- R4: If `load_hi` and `load_lo` are both high in the accepting cycle, the high rate is used.
- R5: Bits are sent in ascending order, from bit 0 of `load_word` up to bit 31.
- R6: The line encoding is: ONE = `tx_one`=1 and `tx_zero`=0; ZERO = `tx_one`=0 and `tx_zero`=1; NULL = both 0. Both wires are never high together.
- R7: Each bit drives its level for the first half of its period, and the line is NULL for the second half.
- R8: After bit 31 the line stays NULL for GAP_BITS bit periods. `busy` stays high for exactly (32+GAP_BITS) bit periods and then drops.
- R9: A load strobe sampled on any clock edge where `busy` is 1 is ignored, even on the edge where `busy` falls. The current word, its rate and its timing do not change.
- R10: For each channel i, `rx_one[i]`/`rx_zero[i]` equal the loopback line when `chan_ext_sel[i]`=0, and equal `ext_one[i]`/`ext_zero[i]` when it is 1.
- R11: A load presented in the first cycle that `busy` reads 0 is accepted, so words can be sent back to back.
- R12: Asserting reset during a transfer abandons it. `busy` drops to 0 and the line goes NULL at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_hi | input | 1 | Load strobe, high-rate word |
| load_lo | input | 1 | Load strobe, low-rate word |
| load_word | input | WORD_W | Word to transmit, bit 0 sent first |
| chan_ext_sel | input | NUM_CH | Per-channel source: 0 loopback, 1 external |
| ext_one | input | NUM_CH | External bus ONE wire per channel |
| ext_zero | input | NUM_CH | External bus ZERO wire per channel |
| busy | output | 1 | Word or gap in progress |
| tx_one | output | 1 | Line ONE wire |
| tx_zero | output | 1 | Line ZERO wire |
| rx_one | output | NUM_CH | Selected ONE wire per receiver |
| rx_zero | output | NUM_CH | Selected ZERO wire per receiver |

## Verification
Two events can fall on the same edge: the gap finishing, which drops `busy`, and a new load strobe. The bench places a load on the exact edge where the gap ends and expects it to be ignored. It then presents a load one cycle later and expects it to be taken, with bit 0 starting at once. Loads are also injected in the middle of both fast and slow words, and the bench checks that the waveform still matches, cycle by cycle, the one it computes from the original word and rate.

// File: rtl/ast_pkg.sv
package ast_pkg;
   // {one_wire, zero_wire}
   typedef enum logic [1:0] {
      LINE_NULL = 2'b00,
      LINE_ZERO = 2'b01,
      LINE_ONE  = 2'b10
   } line_e;
endpackage

// File: rtl/ast_half_timer.sv
module ast_half_timer #(
   parameter int HALF_HI_CYC = 5,
   parameter int LO_RATIO    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   input  logic rate_lo,
   output logic half_done
);
   localparam int MAX_HALF = HALF_HI_CYC * LO_RATIO;
   localparam int CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

   generate
      if (HALF_HI_CYC < 1) begin : g_bad_half
         $error("HALF_HI_CYC must be at least 1");
      end
      if (LO_RATIO < 1) begin : g_bad_ratio
         $error("LO_RATIO must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   assign limit     = rate_lo ? CNT_W'(MAX_HALF - 1) : CNT_W'(HALF_HI_CYC - 1);
   assign half_done = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (restart)    cnt_q <= '0;
      else if (run)        cnt_q <= half_done ? '0 : cnt_q + 1'b1;
   end

   // R2
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_HALF - 1));
endmodule

// File: rtl/ast_sequencer.sv
module ast_sequencer #(
   parameter int WORD_W   = 32,
   parameter int GAP_BITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_hi,
   input  logic              load_lo,
   input  logic [WORD_W-1:0] load_word,
   input  logic              half_done,
   output logic              accept,
   output logic              busy,
   output logic              rate_lo,
   output logic              second_half,
   output logic              drive_en,
   output logic              drive_bit
);
   localparam int SLOTS = WORD_W + GAP_BITS;
   localparam int IDX_W = $clog2(SLOTS);
   localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS - 1);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("WORD_W must be at least 2");
      end
      if (GAP_BITS < 1) begin : g_bad_gap
         $error("GAP_BITS must be at least 1");
      end
   endgenerate

   logic [WORD_W-1:0] sh_q;
   logic [IDX_W-1:0]  idx_q;
   logic              busy_q, rate_q, phase_q;

   assign accept      = (load_hi || load_lo) && !busy_q;
   assign busy        = busy_q;
   assign rate_lo     = rate_q;
   assign second_half = phase_q;
   assign drive_en    = busy_q && !phase_q && (idx_q < IDX_W'(WORD_W));
   assign drive_bit   = sh_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         idx_q   <= '0;
         busy_q  <= 1'b0;
         rate_q  <= 1'b0;
         phase_q <= 1'b0;
      end else if (accept) begin
         sh_q    <= load_word;
         idx_q   <= '0;
         busy_q  <= 1'b1;
         rate_q  <= !load_hi;
         phase_q <= 1'b0;
      end else if (busy_q && half_done) begin
         if (!phase_q) begin
            phase_q <= 1'b1;
         end else begin
            phase_q <= 1'b0;
            sh_q    <= sh_q >> 1;
            if (idx_q == LAST_SLOT) busy_q <= 1'b0;
            else                    idx_q  <= idx_q + 1'b1;
         end
      end
   end

   // R9
   rate_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(rate_q));

   // R8
   busy_end_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(idx_q) == LAST_SLOT);

   // R11
   idle_load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((load_hi || load_lo) && !busy_q) |=> (busy_q && !phase_q && idx_q == '0));
endmodule

// File: rtl/ast_loop_mux.sv
module ast_loop_mux #(
   parameter int NUM_CH = 8
) (
   input  logic              line_one,
   input  logic              line_zero,
   input  logic [NUM_CH-1:0] chan_ext_sel,
   input  logic [NUM_CH-1:0] ext_one,
   input  logic [NUM_CH-1:0] ext_zero,
   output logic [NUM_CH-1:0] rx_one,
   output logic [NUM_CH-1:0] rx_zero
);
   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("NUM_CH must be at least 1");
      end
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         assign rx_one[ch]  = chan_ext_sel[ch] ? ext_one[ch]  : line_one;
         assign rx_zero[ch] = chan_ext_sel[ch] ? ext_zero[ch] : line_zero;
      end
   endgenerate
endmodule

// File: rtl/arinc_selftest_tx.sv
module arinc_selftest_tx #(
   parameter int WORD_W      = 32,
   parameter int GAP_BITS    = 4,
   parameter int HALF_HI_CYC = 5,
   parameter int LO_RATIO    = 8,
   parameter int NUM_CH      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_hi,
   input  logic              load_lo,
   input  logic [WORD_W-1:0] load_word,
   input  logic [NUM_CH-1:0] chan_ext_sel,
   input  logic [NUM_CH-1:0] ext_one,
   input  logic [NUM_CH-1:0] ext_zero,
   output logic              busy,
   output logic              tx_one,
   output logic              tx_zero,
   output logic [NUM_CH-1:0] rx_one,
   output logic [NUM_CH-1:0] rx_zero
);
   import ast_pkg::*;

   logic  accept, half_done, rate_lo, second_half, drive_en, drive_bit;
   line_e line;

   ast_half_timer #(.HALF_HI_CYC(HALF_HI_CYC), .LO_RATIO(LO_RATIO)) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (accept),
      .run       (busy),
      .rate_lo   (rate_lo),
      .half_done (half_done)
   );

   ast_sequencer #(.WORD_W(WORD_W), .GAP_BITS(GAP_BITS)) i_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_hi     (load_hi),
      .load_lo     (load_lo),
      .load_word   (load_word),
      .half_done   (half_done),
      .accept      (accept),
      .busy        (busy),
      .rate_lo     (rate_lo),
      .second_half (second_half),
      .drive_en    (drive_en),
      .drive_bit   (drive_bit)
   );

   always_comb begin
      if (!drive_en)      line = LINE_NULL;
      else if (drive_bit) line = LINE_ONE;
      else                line = LINE_ZERO;
   end

   assign {tx_one, tx_zero} = line;

   ast_loop_mux #(.NUM_CH(NUM_CH)) i_mux (
      .line_one     (tx_one),
      .line_zero    (tx_zero),
      .chan_ext_sel (chan_ext_sel),
      .ext_one      (ext_one),
      .ext_zero     (ext_zero),
      .rx_one       (rx_one),
      .rx_zero      (rx_zero)
   );

   // R6
   no_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_one && tx_zero));

   // R7
   rz_second_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      second_half |-> (!tx_one && !tx_zero));

   // R8
   idle_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!tx_one && !tx_zero));
endmodule

// File: tb/test_arinc_selftest_tx.sv
module test_arinc_selftest_tx;
   localparam int CLK_PERIOD = 10;
   localparam int WW = 32, GAP = 4, HH = 5, LR = 8, NCH = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic load_hi = 1'b0, load_lo = 1'b0;
   logic [WW-1:0] load_word = '0;
   logic [NCH-1:0] chan_ext_sel = '0, ext_one = '0, ext_zero = '0;
   logic busy, tx_one, tx_zero;
   logic [NCH-1:0] rx_one, rx_zero;

   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   arinc_selftest_tx #(.WORD_W(WW), .GAP_BITS(GAP), .HALF_HI_CYC(HH),
                       .LO_RATIO(LR), .NUM_CH(NCH)) i_arinc_selftest_tx (
      .clk(clk), .rst_n(rst_n), .load_hi(load_hi), .load_lo(load_lo),
      .load_word(load_word), .chan_ext_sel(chan_ext_sel), .ext_one(ext_one),
      .ext_zero(ext_zero), .busy(busy), .tx_one(tx_one), .tx_zero(tx_zero),
      .rx_one(rx_one), .rx_zero(rx_zero)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Sends one word; checks every cycle until busy should be low.
   // inject_at >= 0 drives both strobes with junk at that cycle (R9).
   task automatic send(input logic [WW-1:0] w, input bit hi, input bit lo,
                       input int inject_at, input string req);
      int half  = hi ? HH : HH * LR;
      int total = (WW + GAP) * 2 * half;
      @(negedge clk);
      load_word = w; load_hi = hi; load_lo = lo;
      @(negedge clk);
      load_hi = 0; load_lo = 0; load_word = ~w;
      for (int c = 0; c < total; c++) begin
         int bitn = c / (2 * half);
         bit first = (c % (2 * half)) < half;
         logic [1:0] exp;
         logic [NCH-1:0] eo, ez;
         if (bitn < WW && first) exp = w[bitn] ? 2'b10 : 2'b01;
         else                    exp = 2'b00;
         chk({req, " busy"}, 32'(busy), 32'd1);
         chk({req, " line R5 R6 R7 R8"}, 32'({tx_one, tx_zero}), 32'(exp));
         for (int ch = 0; ch < NCH; ch++) begin
            eo[ch] = chan_ext_sel[ch] ? ext_one[ch]  : exp[1];
            ez[ch] = chan_ext_sel[ch] ? ext_zero[ch] : exp[0];
         end
         chk("R10 loopback", 32'({rx_one, rx_zero}), 32'({eo, ez}));
         if (c == inject_at) begin load_hi = 1; load_lo = 1; end
         @(negedge clk);
         load_hi = 0; load_lo = 0;
      end
      chk({req, " R8 busy end"}, 32'(busy), 32'd0);
      chk({req, " R8 null end"}, 32'({tx_one, tx_zero}), 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", 32'(busy), 32'd0);
      chk("R1 line in reset", 32'({tx_one, tx_zero}), 32'd0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 busy after reset", 32'(busy), 32'd0);
      chk("R1 line after reset", 32'({tx_one, tx_zero}), 32'd0);

      // R2 R5: high rate, assorted patterns
      send(32'h0000_0000, 1, 0, -1, "R2");
      send(32'hFFFF_FFFF, 1, 0, -1, "R2");
      send(32'h0000_0001, 1, 0, -1, "R5");
      for (int k = 0; k < WW; k += 5) begin
         chan_ext_sel = NCH'(k * 37); ext_one = NCH'(k * 11); ext_zero = ~NCH'(k * 11);
         send(32'h1 << k, 1, 0, -1, "R5 walk");
      end
      // R3: low rate
      chan_ext_sel = 8'hA5; ext_one = 8'h0F; ext_zero = 8'h30;
      send(32'hA5C3_1E78, 0, 1, -1, "R3");
      // R4: both strobes, high wins
      send(32'h8000_0000, 1, 1, -1, "R4");
      // R9: load in the middle of fast and slow words
      send(32'h1234_5678, 1, 0, 77, "R9 mid");
      send(32'hDEAD_BEEF, 0, 1, 1501, "R9 mid slow");
      // R9: load on the edge busy falls, then R11 back to back
      send(32'h5A5A_0FF0, 1, 0, (WW + GAP) * 2 * HH - 1, "R9 edge");
      chk("R9 not restarted", 32'(busy), 32'd0);
      @(negedge clk);
      load_word = 32'hC001_D00D; load_hi = 1;
      @(negedge clk);
      load_hi = 0;
      chk("R11 accepted", 32'(busy), 32'd1);
      chk("R11 first bit", 32'({tx_one, tx_zero}), 32'd2);
      // R12: reset mid-transfer
      repeat (40) @(negedge clk);
      rst_n = 0;
      #1;
      chk("R12 busy", 32'(busy), 32'd0);
      chk("R12 line", 32'({tx_one, tx_zero}), 32'd0);
      @(negedge clk);
      rst_n = 1;
      send(32'h0F0F_F0F0, 0, 1, -1, "R3 after reset");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule